// File: doc/BRIEF.md
# Sprite Memory Page Copier

This block fills a 256-byte sprite attribute store from system memory. The processor writes a page number to one fixed trigger address. The engine keeps that byte and uses it as the high byte of every source address. It then reads the 256 bytes of the page in order, with the low address byte counting up from 0x00. Each byte it fetches is pushed into the sprite store through a data port. Every push moves the sprite address pointer on by one.

The processor can load the sprite address pointer through a second fixed address before it starts a copy. This sets where in the store the copied page begins. The pointer wraps, so a copy can start anywhere and still covers all 256 entries. While the copy runs, `busy_o` is high so the surrounding system can hold the processor off. A one-cycle `done_o` pulse marks the end of the copy. A separate read port lets the store be inspected.

Top module: `sprite_dma`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0, `page_o` is 0x00 and `spr_addr_o` is 0x00.
- R2: When `cpu_we_i` is high with `cpu_addr_i` equal to the trigger address (default 0x4014) and the block is idle, `page_o` takes `cpu_wdata_i` at that edge and a copy starts. A write to any other address neither starts a copy nor changes `page_o`.
- R3: A copy issues exactly 256 reads. Each read is a one-cycle `mem_rd_o` pulse. The reads go to `{page, k}` with k running 0x00 to 0xFF in ascending order. The memory returns its byte on `mem_rdata_i` in the cycle after the read pulse.
- R4: The k-th byte read is written to the sprite store at the pointer value that `spr_addr_o` holds at that moment. After each write, `spr_addr_o` goes up by one and wraps from 0xFF to 0x00. After a full copy it is back at its starting value.
- R5: `busy_o` is high from the cycle after the trigger edge for exactly 513 cycles: one alignment cycle, then a read cycle and a write cycle per byte.
- R6: `done_o` is high for exactly one cycle, which is the first cycle in which `busy_o` is low again.
- R7: A trigger write that arrives while `busy_o` is high is ignored. `page_o` keeps its value and the copy in progress goes on unchanged.
- R8: A write to the pointer address (default 0x2003) while idle loads `cpu_wdata_i` into `spr_addr_o`. The same write is ignored while `busy_o` is high.
- R9: `spr_rdata_o` shows, without a clock delay, the sprite store entry selected by `spr_raddr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_we_i | input | 1 | Processor write strobe |
| cpu_addr_i | input | 16 | Processor write address |
| cpu_wdata_i | input | 8 | Processor write data |
| page_o | output | 8 | Last accepted source page |
| busy_o | output | 1 | Copy in progress |
| done_o | output | 1 | One-cycle end-of-copy pulse |
| mem_rd_o | output | 1 | Source read request |
| mem_addr_o | output | 16 | Source read address |
| mem_rdata_i | input | 8 | Source data, valid the cycle after the request |
| spr_addr_o | output | 8 | Sprite address pointer |
| spr_raddr_i | input | 8 | Sprite store inspection address |
| spr_rdata_o | output | 8 | Sprite store inspection data |

## Verification
The bench builds the block with its default parameters: a 16-bit address, 8-bit data and the two default register addresses. These values make the 256-byte copy and the 8-bit pointer wrap reachable in a few hundred cycles. Copies start from pointer 0x00 and from 0xF0, so the 0xFF to 0x00 wrap falls in the middle of a page. Other copies test triggers and pointer loads sent while busy, and writes to addresses next to the trigger.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ALIGN,
    ST_READ,
    ST_WRITE
  } sdma_state_e;
endpackage

// File: rtl/sdma_trigger.sv
module sdma_trigger #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h4014
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  input  logic              busy_i,
  output logic [DATA_W-1:0] page_o,
  output logic              start_o
);
  logic [DATA_W-1:0] page_q;

  assign start_o = cpu_we_i && (cpu_addr_i == TRIG_ADDR) && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      page_q <= '0;
    else if (start_o) page_q <= cpu_wdata_i;
  end

  assign page_o = page_q;

  assert_page_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(page_o));
endmodule

// File: rtl/sdma_seq.sv
module sdma_seq
  import sdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int OFS_W = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] page_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              spr_we_o,
  output logic [DATA_W-1:0] spr_wdata_o,
  output logic              busy_o,
  output logic              done_o
);
  sdma_state_e state_q, state_d;
  logic [OFS_W-1:0] cnt_q, cnt_d;
  logic done_q, done_d;
  logic last;

  assign last = (cnt_q == {OFS_W{1'b1}});

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (start_i) begin
                  state_d = ST_ALIGN;
                  cnt_d   = '0;
                end
      ST_ALIGN: state_d = ST_READ;
      ST_READ:  state_d = ST_WRITE;
      ST_WRITE: begin
        cnt_d = OFS_W'(cnt_q + 1'b1);
        if (last) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          state_d = ST_READ;
        end
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign mem_rd_o    = (state_q == ST_READ);
  assign mem_addr_o  = {page_i, cnt_q};
  assign spr_we_o    = (state_q == ST_WRITE);
  assign spr_wdata_o = mem_rdata_i;

  assert_busy_on_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  assert_done_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_after_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
  assert_read_then_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> spr_we_o);
endmodule

// File: rtl/sdma_spr_mem.sv
module sdma_spr_mem #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PTR_W  = 8,
  parameter logic [ADDR_W-1:0] PTR_ADDR = 16'h2003,
  localparam int DEPTH = 1 << PTR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  input  logic              busy_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PTR_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [PTR_W-1:0]  ptr_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  ptr_q;
  logic              ptr_load;

  assign ptr_load = cpu_we_i && (cpu_addr_i == PTR_ADDR) && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ptr_q <= '0;
    else if (we_i)     ptr_q <= PTR_W'(ptr_q + 1'b1);
    else if (ptr_load) ptr_q <= PTR_W'(cpu_wdata_i);
  end

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[ptr_q] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
  assign ptr_o   = ptr_q;

  assert_ptr_inc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (ptr_q == PTR_W'($past(ptr_q) + 1'b1)));
  assert_we_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> busy_i);
  assert_ptr_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !we_i) |=> $stable(ptr_q));
endmodule

// File: rtl/sprite_dma.sv
module sprite_dma #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h4014,
  parameter logic [ADDR_W-1:0] PTR_ADDR  = 16'h2003,
  localparam int OFS_W = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] page_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [OFS_W-1:0]  spr_addr_o,
  input  logic [OFS_W-1:0]  spr_raddr_i,
  output logic [DATA_W-1:0] spr_rdata_o
);
  logic              start;
  logic              busy;
  logic              spr_we;
  logic [DATA_W-1:0] spr_wdata;

  sdma_trigger #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TRIG_ADDR(TRIG_ADDR)) i_trigger (
    .clk_i, .rst_ni, .cpu_we_i, .cpu_addr_i, .cpu_wdata_i,
    .busy_i (busy),
    .page_o,
    .start_o(start)
  );

  sdma_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_seq (
    .clk_i, .rst_ni,
    .start_i    (start),
    .page_i     (page_o),
    .mem_rdata_i,
    .mem_rd_o,
    .mem_addr_o,
    .spr_we_o   (spr_we),
    .spr_wdata_o(spr_wdata),
    .busy_o     (busy),
    .done_o
  );

  sdma_spr_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(OFS_W), .PTR_ADDR(PTR_ADDR)) i_spr (
    .clk_i, .rst_ni, .cpu_we_i, .cpu_addr_i, .cpu_wdata_i,
    .busy_i (busy),
    .we_i   (spr_we),
    .wdata_i(spr_wdata),
    .raddr_i(spr_raddr_i),
    .rdata_o(spr_rdata_o),
    .ptr_o  (spr_addr_o)
  );

  assign busy_o = busy;

  assert_read_page_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> (mem_addr_o[ADDR_W-1:OFS_W] == page_o));
endmodule

// File: tb/test_sprite_dma.sv
module test_sprite_dma;
  localparam logic [15:0] TRIG = 16'h4014;
  localparam logic [15:0] PTR  = 16'h2003;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  page;
  logic        busy, done, mem_rd;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic [7:0]  spr_addr;
  logic [7:0]  spr_raddr = '0;
  logic [7:0]  spr_rdata;

  int total = 0;
  int bad = 0;

  logic [7:0] exp_page = '0;
  int         rd_cnt = 0;
  int         rd_err = 0;

  always #10 clk = ~clk;

  sprite_dma i_sprite_dma (
    .clk_i(clk), .rst_ni(rst_n), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .page_o(page), .busy_o(busy), .done_o(done),
    .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .spr_addr_o(spr_addr), .spr_raddr_i(spr_raddr), .spr_rdata_o(spr_rdata)
  );

  function automatic logic [7:0] src_byte(logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ 8'h5A;
  endfunction

  // source memory: data one cycle after request; address sequence monitor
  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= src_byte(mem_addr);
      if (mem_addr != {exp_page, 8'(rd_cnt)}) rd_err <= rd_err + 1;
      rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  // counts busy cycles from the negedge after the trigger edge
  task automatic wait_copy(output int busy_cycles);
    busy_cycles = 0;
    while (busy) begin
      busy_cycles++;
      @(negedge clk);
    end
  endtask

  task automatic check_store(input logic [7:0] pg, input logic [7:0] base, input string req);
    int errs = 0;
    int first_bad = -1;
    for (int k = 0; k < 256; k++) begin
      spr_raddr = 8'(base + k);
      #1;
      if (spr_rdata != src_byte({pg, 8'(k)})) begin
        errs++;
        if (first_bad < 0) first_bad = k;
      end
    end
    check(errs == 0, req, errs, 0);
  endtask

  task automatic t_reset;
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(done == 1'b0, "R1 done", done, 0);
    check(page == 8'h00, "R1 page", page, 0);
    check(spr_addr == 8'h00, "R1 spr_addr", spr_addr, 0);
  endtask

  task automatic t_basic;
    int n;
    exp_page = 8'h03; rd_cnt = 0; rd_err = 0;
    cpu_write(TRIG, 8'h03);
    check(busy == 1'b1, "R5 busy after trigger", busy, 1);
    check(page == 8'h03, "R2 page captured", page, 8'h03);
    wait_copy(n);
    check(n == 513, "R5 busy length", n, 513);
    check(done == 1'b1, "R6 done high", done, 1);
    @(negedge clk);
    check(done == 1'b0, "R6 done one cycle", done, 0);
    check(rd_cnt == 256, "R3 read count", rd_cnt, 256);
    check(rd_err == 0, "R3 read addresses", rd_err, 0);
    check(spr_addr == 8'h00, "R4 pointer returns", spr_addr, 0);
    check_store(8'h03, 8'h00, "R4 R9 store contents base 00");
  endtask

  task automatic t_wrap;
    int n;
    cpu_write(PTR, 8'hF0);
    check(spr_addr == 8'hF0, "R8 pointer load", spr_addr, 8'hF0);
    exp_page = 8'h81; rd_cnt = 0; rd_err = 0;
    cpu_write(TRIG, 8'h81);
    wait_copy(n);
    check(n == 513, "R5 busy length wrap", n, 513);
    check(rd_err == 0 && rd_cnt == 256, "R3 reads page 81", rd_err, 0);
    check(spr_addr == 8'hF0, "R4 pointer after wrap", spr_addr, 8'hF0);
    spr_raddr = 8'h00; #1;
    check(spr_rdata == src_byte(16'h8110), "R4 wrap entry 00", spr_rdata, src_byte(16'h8110));
    spr_raddr = 8'hEF; #1;
    check(spr_rdata == src_byte(16'h81FF), "R4 last entry EF", spr_rdata, src_byte(16'h81FF));
    check_store(8'h81, 8'hF0, "R4 store contents base F0");
  endtask

  task automatic t_ignore;
    int n;
    cpu_write(PTR, 8'h00);
    exp_page = 8'h05; rd_cnt = 0; rd_err = 0;
    cpu_write(TRIG, 8'h05);
    repeat (20) @(negedge clk);
    cpu_write(TRIG, 8'h77);
    check(page == 8'h05, "R7 page kept while busy", page, 8'h05);
    cpu_write(PTR, 8'h33);
    wait_copy(n);
    check(page == 8'h05, "R7 page after copy", page, 8'h05);
    check(rd_err == 0 && rd_cnt == 256, "R7 copy undisturbed", rd_err, 0);
    check(spr_addr == 8'h00, "R8 pointer load ignored while busy", spr_addr, 0);
    check_store(8'h05, 8'h00, "R7 store contents");
  endtask

  task automatic t_other;
    cpu_write(16'h4015, 8'h99);
    check(busy == 1'b0, "R2 neighbour address no start", busy, 0);
    check(page == 8'h05, "R2 neighbour address page", page, 8'h05);
    cpu_write(16'h2014, 8'h44);
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R2 other address no start", busy, 0);
    check(page == 8'h05, "R2 other address page", page, 8'h05);
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_wrap();
    t_ignore();
    t_other();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule